// File: doc/BRIEF.md
# Edge-Select GPIO Port Controller

This block is a sixteen-line general-purpose I/O port controlled through a small register interface. Software sets each line as an input or an output. An output latch drives the pins, but only on lines set as outputs; the pin enable vector tells the pad ring which lines to drive. The pins are sampled once per clock. The previous sample is kept, so a change between two samples counts as an edge.

Each input line has one polarity bit. It selects whether the line reports a rising edge or a falling edge. A per-line disable bit blocks reporting. A reported edge sets a sticky status bit. The bit stays set until software writes a 1 to it. Any status bit that is set holds the single interrupt output high.

A three-state access machine serves the register interface. In `BUS_IDLE` there is no response. A mapped halfword request moves it to `BUS_DONE`: a normal response with data. Any other request moves it to `BUS_FAULT`: a zero-data response with the error flag. From any state, a request in the current cycle selects `BUS_DONE` or `BUS_FAULT` for the next cycle. No request returns the machine to `BUS_IDLE`. Requests may therefore be issued back to back.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, these registers read 16'hFFFF: output latch (0x04), direction (0x08), polarity (0x0C), disable (0x10) and pin enable (0x18). The status register (0x14) and the sampled inputs read zero. `pin_oe`, `pin_out` and `irq` are low.
- R2: `pin_oe[i]` is the inverse of direction bit i, where 1 means input and 0 means output. `pin_out[i]` equals the output latch bit when `pin_oe[i]` is 1, and 0 otherwise. Both follow a register write in the cycle after the request.
- R3: Polarity bit 1 reports a 0-to-1 change on an enabled input line and ignores a 1-to-0 change. A pin change applied before clock edge n sets the status bit, and raises `irq`, after edge n+1.
- R4: Polarity bit 0 reports a 1-to-0 change and ignores a 0-to-1 change, with the same timing as R3.
- R5: A line whose disable bit is 1, or whose direction bit is 0, never sets its status bit.
- R6: A write to 0x14 clears each status bit written as 1 and leaves the other bits unchanged. `irq` stays high while any status bit is set and falls in the cycle after the last bit is cleared. If an edge and a clear reach the same bit in the same cycle, the bit stays set.
- R7: A read of 0x00 returns the sampled inputs ANDed with the pin enable register (0x18).
- R8: A request is faulted if its size code is not 1 (halfword: code 0 byte, 1 halfword, 2 word), if its address is not a multiple of 4, or if its offset is above 0x18. A faulted request returns zero data, pulses `err` for one cycle, and changes no register.
- R9: A halfword write to 0x00 is accepted without error and changes nothing.
- R10: Each request gets exactly one response cycle (`rsp_valid`) in the cycle after it is sampled. Without a request, `rsp_valid` and `err` are low.
- R11: A direction write that turns a line with latch 1 from output to input drops that pin's driven value to 0. Turning it back to output drives 1 again, with no new latch write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled each clock |
| we | input | 1 | 1 for write, 0 for read |
| addr | input | 5 | Byte offset of the register |
| size | input | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with rsp_valid |
| rsp_valid | output | 1 | Response cycle marker |
| err | output | 1 | One-cycle fault marker for a rejected access |
| pin_in | input | 16 | Line input levels, already synchronous |
| pin_out | output | 16 | Driven line values |
| pin_oe | output | 16 | Per-line drive enable |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
Most internal faults become visible at the ports within one to three cycles. A wrong stored previous sample either reports a phantom edge or drops a real one. It shows as a status or `irq` change exactly two edges after the pin moves, or as the absence of that change. A wrong direction or latch bit shows on `pin_out` and `pin_oe` in the cycle after the write. A faulty access-machine state shows in the next response cycle, as a missing or extra `rsp_valid`, as `err` on a good access, or as nonzero data on a fault. Sticky status corruption persists, so it is caught at the next read of 0x14 or at `irq`.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_DONE  = 2'd1,
        BUS_FAULT = 2'd2
    } bus_state_e;

    typedef enum logic [2:0] {
        REG_INPUT  = 3'd0,
        REG_LATCH  = 3'd1,
        REG_DIR    = 3'd2,
        REG_POL    = 3'd3,
        REG_DIS    = 3'd4,
        REG_STATUS = 3'd5,
        REG_PINEN  = 3'd6,
        REG_NONE   = 3'd7
    } reg_sel_e;

    localparam logic [1:0] SIZE_HALF = 2'd1;
    localparam int unsigned REG_COUNT = 7;

endpackage

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output reg_sel_e          sel,
    output logic              wr_en,
    output logic              rd_en,
    output logic              rsp_valid,
    output logic              err
);

    localparam int IDX_W = ADDR_W - 2;

    bus_state_e state_q, state_d;
    logic       legal;
    logic [IDX_W-1:0] idx;

    assign idx   = addr[ADDR_W-1:2];
    assign legal = (size == SIZE_HALF) && (addr[1:0] == 2'b00)
                   && (int'(idx) < int'(REG_COUNT));

    always_comb begin
        sel = REG_NONE;
        if (legal) begin
            sel = reg_sel_e'(idx[2:0]);
        end
    end

    assign wr_en = req && legal && we;
    assign rd_en = req && legal && !we;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE, BUS_DONE, BUS_FAULT: begin
                if (!req)       state_d = BUS_IDLE;
                else if (legal) state_d = BUS_DONE;
                else            state_d = BUS_FAULT;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        rsp_valid = 1'b0;
        err       = 1'b0;
        unique case (state_q)
            BUS_IDLE:  ;
            BUS_DONE:  rsp_valid = 1'b1;
            BUS_FAULT: begin
                rsp_valid = 1'b1;
                err       = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
    import gpio_port_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  reg_sel_e         sel,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] sampled,
    input  logic [LINES-1:0] status,
    output logic [LINES-1:0] latch_q,
    output logic [LINES-1:0] dir_q,
    output logic [LINES-1:0] pol_q,
    output logic [LINES-1:0] dis_q,
    output logic [LINES-1:0] pinen_q,
    output logic [LINES-1:0] clr_bits,
    output logic [LINES-1:0] rdata_q
);

    localparam logic [LINES-1:0] ALL_ONES = {LINES{1'b1}};

    logic [LINES-1:0] rd_mux;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= ALL_ONES;
            dir_q   <= ALL_ONES;
            pol_q   <= ALL_ONES;
            dis_q   <= ALL_ONES;
            pinen_q <= ALL_ONES;
        end else if (wr_en) begin
            unique case (sel)
                REG_LATCH: latch_q <= wdata;
                REG_DIR:   dir_q   <= wdata;
                REG_POL:   pol_q   <= wdata;
                REG_DIS:   dis_q   <= wdata;
                REG_PINEN: pinen_q <= wdata;
                default: ;
            endcase
        end
    end

    assign clr_bits = (wr_en && sel == REG_STATUS) ? wdata : '0;

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            REG_INPUT:  rd_mux = sampled & pinen_q;
            REG_LATCH:  rd_mux = latch_q;
            REG_DIR:    rd_mux = dir_q;
            REG_POL:    rd_mux = pol_q;
            REG_DIS:    rd_mux = dis_q;
            REG_STATUS: rd_mux = status;
            REG_PINEN:  rd_mux = pinen_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
        else            rdata_q <= '0;
    end

endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_in,
    input  logic [LINES-1:0] dir,
    input  logic [LINES-1:0] pol,
    input  logic [LINES-1:0] dis,
    input  logic [LINES-1:0] clr,
    output logic [LINES-1:0] sampled,
    output logic [LINES-1:0] status,
    output logic             irq
);

    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] hit;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic rise, fall;
        assign rise   = sampled[i] & ~prev_q[i];
        assign fall   = ~sampled[i] & prev_q[i];
        assign hit[i] = (pol[i] ? rise : fall) & dir[i] & ~dis[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sampled[i] <= 1'b0;
                prev_q[i]  <= 1'b0;
                status[i]  <= 1'b0;
            end else begin
                sampled[i] <= pin_in[i];
                prev_q[i]  <= sampled[i];
                status[i]  <= hit[i] | (status[i] & ~clr[i]);
            end
        end
    end

    assign irq = |status;

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_port_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [LINES-1:0]  wdata,
    output logic [LINES-1:0]  rdata,
    output logic              rsp_valid,
    output logic              err,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe,
    output logic              irq
);

    reg_sel_e         sel;
    logic             wr_en, rd_en;
    logic [LINES-1:0] latch_q, dir_q, pol_q, dis_q, pinen_q;
    logic [LINES-1:0] clr_bits, sampled, status;

    gpio_bus_fsm #(.ADDR_W(ADDR_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .we        (we),
        .addr      (addr),
        .size      (size),
        .sel       (sel),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .rsp_valid (rsp_valid),
        .err       (err)
    );

    gpio_reg_file #(.LINES(LINES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .sampled  (sampled),
        .status   (status),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .pol_q    (pol_q),
        .dis_q    (dis_q),
        .pinen_q  (pinen_q),
        .clr_bits (clr_bits),
        .rdata_q  (rdata)
    );

    gpio_edge_det #(.LINES(LINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .dir     (dir_q),
        .pol     (pol_q),
        .dis     (dis_q),
        .clr     (clr_bits),
        .sampled (sampled),
        .status  (status),
        .irq     (irq)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_drv
        assign pin_oe[i]  = ~dir_q[i];
        assign pin_out[i] = pin_oe[i] & latch_q[i];
    end

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
    parameter int LINES  = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [1:0]        size,
    input logic [LINES-1:0]  rdata,
    input logic              rsp_valid,
    input logic              err,
    input logic [LINES-1:0]  pin_in,
    input logic [LINES-1:0]  pin_out,
    input logic [LINES-1:0]  pin_oe,
    input logic              irq
);

    localparam logic [ADDR_W-1:0] STATUS_OFF = ADDR_W'(5'h14);

    AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R2

    AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(pin_in, 2) != $past(pin_in, 3))); // R3

    AST_IRQ_DROP_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(req && we && addr == STATUS_OFF && size == 2'd1)); // R6

    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rsp_valid && rdata == '0)); // R8

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req)); // R10

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .we        (we),
    .addr      (addr),
    .size      (size),
    .rdata     (rdata),
    .rsp_valid (rsp_valid),
    .err       (err),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
);

// File: tb/gpio_edge_port_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req, we;
    logic [4:0]  addr;
    logic [1:0]  size;
    logic [15:0] wdata, rdata, pin_in, pin_out, pin_oe;
    logic        rsp_valid, err, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [16:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    gpio_edge_port dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .rdata(rdata), .rsp_valid(rsp_valid), .err(err),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [4:0] a, input logic [1:0] sz,
                       input logic [15:0] d, input logic [15:0] exp,
                       input logic exp_err, input string tag);
        req = 1'b1; we = w; addr = a; size = sz; wdata = d;
        q_exp.push_back({exp_err, exp});
        q_tag.push_back(tag);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input string tag);
        acc(1'b1, a, 2'd1, d, 16'h0000, 1'b0, tag);
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
        acc(1'b0, a, 2'd1, 16'h0000, exp, 1'b0, tag);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // monitor: pops expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_exp.size() == 0) begin
                check("R10 unexpected response", 32'(rsp_valid), 32'd0);
            end else begin
                logic [16:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                check(t, {15'd0, err, rdata}, {15'd0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = 0; we = 0; addr = 0; size = 2'd1; wdata = 0; pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 pin_out", 32'(pin_out), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rd(5'h04, 16'hFFFF, "R1 latch");
        rd(5'h08, 16'hFFFF, "R1 direction");
        rd(5'h0C, 16'hFFFF, "R1 polarity");
        rd(5'h10, 16'hFFFF, "R1 disable");
        rd(5'h14, 16'h0000, "R1 status");
        rd(5'h18, 16'hFFFF, "R1 pin enable");
        rd(5'h00, 16'h0000, "R1 sampled inputs");

        // R7 input read gated by pin enable
        pin_in = 16'hA5C3;
        settle();
        rd(5'h00, 16'hA5C3, "R7 full enable");
        wr(5'h18, 16'h0FF0, "R7 write pin enable");
        rd(5'h00, 16'h05C0, "R7 partial enable");
        wr(5'h18, 16'hFFFF, "R7 restore");

        // R9 write to input data ignored
        wr(5'h00, 16'h1234, "R9 write accepted");
        rd(5'h00, 16'hA5C3, "R9 input unchanged");

        // R2 output gating
        wr(5'h04, 16'h1234, "R2 latch write");
        check("R2 no drive while inputs", 32'(pin_out), 32'h0);
        wr(5'h08, 16'hFF00, "R2 dir write");
        check("R2 pin_oe", 32'(pin_oe), 32'h00FF);
        check("R2 pin_out", 32'(pin_out), 32'h0034);

        // R11 direction change with latch 1
        wr(5'h04, 16'h00F0, "R11 latch");
        check("R11 drive", 32'(pin_out), 32'h00F0);
        wr(5'h08, 16'hFFF0, "R11 to input");
        check("R11 released", 32'(pin_out), 32'h0000);
        wr(5'h08, 16'hFF00, "R11 back to output");
        check("R11 redriven", 32'(pin_out), 32'h00F0);

        // R3 rising polarity
        wr(5'h08, 16'hFFFF, "R3 all inputs");
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        wr(5'h10, 16'h0000, "R3 enable reporting");
        rd(5'h14, 16'h0000, "R3 status clear");
        pin_in[3] = 1'b1;
        @(negedge clk);
        check("R3 irq not before second edge", 32'(irq), 32'h0);
        @(negedge clk);
        check("R3 irq after rise", 32'(irq), 32'h1);
        rd(5'h14, 16'h0008, "R3 status rise");
        pin_in[3] = 1'b0;
        settle();
        rd(5'h14, 16'h0008, "R3 fall ignored");

        // R6 write-one-clear, irq held by remaining bits
        pin_in[6] = 1'b1;
        settle();
        wr(5'h14, 16'h0008, "R6 clear one");
        check("R6 irq held", 32'(irq), 32'h1);
        rd(5'h14, 16'h0040, "R6 other bit kept");
        wr(5'h14, 16'h0040, "R6 clear last");
        check("R6 irq dropped", 32'(irq), 32'h0);

        // R4 falling polarity
        wr(5'h0C, 16'hFFFE, "R4 falling on line 0");
        pin_in[0] = 1'b1;
        settle();
        rd(5'h14, 16'h0000, "R4 rise ignored");
        pin_in[0] = 1'b0;
        settle();
        check("R4 irq after fall", 32'(irq), 32'h1);
        rd(5'h14, 16'h0001, "R4 status fall");
        wr(5'h14, 16'h0001, "R4 clear");

        // R5 disabled or output lines
        wr(5'h10, 16'h0002, "R5 disable line 1");
        pin_in[1] = 1'b1;
        settle();
        wr(5'h08, 16'hFFFB, "R5 line 2 output");
        pin_in[2] = 1'b1;
        settle();
        rd(5'h14, 16'h0000, "R5 status stays clear");
        check("R5 irq low", 32'(irq), 32'h0);

        // R6 set wins over same-cycle clear
        pin_in[5] = 1'b1;
        @(negedge clk);
        wr(5'h14, 16'h0020, "R6 clear racing edge");
        rd(5'h14, 16'h0020, "R6 set wins");
        wr(5'h14, 16'h0020, "R6 clear");
        rd(5'h14, 16'h0000, "R6 cleared");

        // R8 faulted accesses
        acc(1'b0, 5'h04, 2'd2, 16'h0000, 16'h0000, 1'b1, "R8 word read");
        acc(1'b1, 5'h04, 2'd0, 16'h0000, 16'h0000, 1'b1, "R8 byte write");
        rd(5'h04, 16'h00F0, "R8 latch untouched");
        acc(1'b0, 5'h1C, 2'd1, 16'h0000, 16'h0000, 1'b1, "R8 unmapped read");
        acc(1'b1, 5'h06, 2'd1, 16'hFFFF, 16'h0000, 1'b1, "R8 misaligned write");
        rd(5'h04, 16'h00F0, "R8 latch still untouched");

        // R10 no response when idle
        @(negedge clk);
        check("R10 rsp_valid idle", 32'(rsp_valid), 32'h0);
        check("R8 err single pulse", 32'(err), 32'h0);
        check("R10 all responses seen", 32'(q_exp.size()), 32'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule